// File: doc/BRIEF.md
# DMA interrupt and control register block

This block is the register file between a processor's simple 32-bit register bus and an external DMA engine. It holds an interrupt status word, an interrupt mask word, a DMA priority/enable word and a DMA interrupt control word. It also holds, for each of seven channels, a memory address word, a block control word and a channel control word. Software programs a channel and sets its go bit. The block sends a one-cycle start strobe to the engine once that channel is also enabled in the enable word.

When the engine reports that a channel has finished, the block drops that channel's go bit. If completion interrupts are enabled for the channel, it raises the channel's flag in the DMA interrupt word and sets the DMA cause bit in the status word. A single interrupt line is high while any status bit is unmasked.

Software can only clear status bits. A status write keeps a bit only where the old status, the mask and the written data all have a one. In the DMA interrupt word, the low 24 bits are plain storage and the top 8 flag bits are write-one-to-clear.

Top module: `dma_irq_regs`

## Requirements
- R1: After reset every register reads zero, and start_o and irq_o are low.
- R2: The mask word (offset 0x074) is plain read/write. A write to the status word (offset 0x070) leaves it equal to old status AND mask AND written data, so a write never sets a status bit.
- R3: A write to the DMA interrupt word (offset 0x0F4) loads bits 23..0 from the data. In the same write, bits 31..24 are cleared where the data bit is 1 and kept where it is 0.
- R4: Channel n (0..6) has its address word at 0x080+0x10*n, its block word at +0x4 and its control word at +0x8. The enable word sits at 0x0F0. All of these are plain read/write, apart from the hardware clear in R6.
- R5: start_o[n] pulses for exactly one cycle when (control bit 24 of channel n AND enable-word bit 4n+3) goes from false to true. It is high in the cycle after the register write that makes the condition true.
- R6: done_i[n] clears control bit 24 of channel n at the next clock edge.
- R7: done_i[n] with DMA interrupt bit 16+n set sets flag bit 24+n and status bit 3. With bit 16+n clear, neither bit changes.
- R8: Hardware set and clear events win over a bus write in the same cycle: a completion flag or status bit 3 that is being set survives a clearing write, and done_i clears a go bit that is being written to 1.
- R9: irq_o is high exactly when (status AND mask) is nonzero.
- R10: Reads of offsets that map to no register (for example 0x000, 0x07C, 0x08C, 0x0F8) return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 12 | Byte offset of the register, word aligned |
| we_i | input | 1 | Write strobe for the addressed register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Combinational read data of the addressed register |
| done_i | input | 7 | Per-channel transfer-complete strobe from the engine |
| start_o | output | 7 | Per-channel one-cycle start strobe to the engine |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume that done_i is a single-cycle strobe. They also assume that the bus addresses only word-aligned offsets, so a write lands in at most one register. The stimulus writes only to mapped offsets, with random data. It raises random done_i patterns in about a quarter of the cycles, sometimes in the same cycle as a clearing write to the same state. Reads of unmapped offsets happen only in idle cycles with the write strobe low.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  localparam logic [11:0] OFS_ISTAT   = 12'h070;
  localparam logic [11:0] OFS_IMASK   = 12'h074;
  localparam logic [11:0] OFS_CH_BASE = 12'h080;
  localparam logic [11:0] OFS_DPCR    = 12'h0F0;
  localparam logic [11:0] OFS_DICR    = 12'h0F4;
  localparam int unsigned GO_BIT      = 24;
  localparam int unsigned EN_LSB      = 16;
  localparam int unsigned FLAG_LSB    = 24;
  localparam int unsigned DMA_CAUSE   = 3;

  typedef enum logic [1:0] {
    CH_ADDR = 2'd0,
    CH_BLK  = 2'd1,
    CH_CTRL = 2'd2,
    CH_NONE = 2'd3
  } ch_reg_e;
endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_irq_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  ch_reg_e           reg_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              en_i,
  input  logic              done_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              start_o
);
  logic [DATA_W-1:0] madr_q, bcr_q, chcr_q;
  logic cond, cond_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      madr_q <= '0;
      bcr_q  <= '0;
      chcr_q <= '0;
    end else begin
      if (we_i && sel_i) begin
        unique case (reg_i)
          CH_ADDR: madr_q <= wdata_i;
          CH_BLK:  bcr_q  <= wdata_i;
          CH_CTRL: chcr_q <= wdata_i;
          default: ;
        endcase
      end
      // engine completion wins over a same-cycle write
      if (done_i) chcr_q[GO_BIT] <= 1'b0;
    end
  end

  assign cond = chcr_q[GO_BIT] & en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cond_q <= 1'b0;
    else         cond_q <= cond;
  end

  assign start_o = cond & ~cond_q;

  always_comb begin
    rdata_o = '0;
    if (sel_i) begin
      unique case (reg_i)
        CH_ADDR: rdata_o = madr_q;
        CH_BLK:  rdata_o = bcr_q;
        CH_CTRL: rdata_o = chcr_q;
        default: rdata_o = '0;
      endcase
    end
  end

  // R5
  start_one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o);
  // R6
  done_clears_go_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !chcr_q[GO_BIT]);
endmodule

// File: rtl/dma_irq_ctrl.sv
module dma_irq_ctrl
  import dma_irq_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned NUM_CH = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_istat_i,
  input  logic              wr_imask_i,
  input  logic              wr_dpcr_i,
  input  logic              wr_dicr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [NUM_CH-1:0] done_i,
  output logic [DATA_W-1:0] istat_o,
  output logic [DATA_W-1:0] imask_o,
  output logic [DATA_W-1:0] dpcr_o,
  output logic [DATA_W-1:0] dicr_o,
  output logic              irq_o
);
  localparam logic [DATA_W-1:0] FLAG_MASK = {{(DATA_W-FLAG_LSB){1'b1}}, {FLAG_LSB{1'b0}}};

  logic [DATA_W-1:0] istat_q, imask_q, dpcr_q, dicr_q;
  logic [DATA_W-1:0] istat_d, dicr_d;
  logic [NUM_CH-1:0] ev;

  assign ev = done_i & dicr_q[EN_LSB +: NUM_CH];

  always_comb begin
    istat_d = istat_q;
    if (wr_istat_i) istat_d = istat_q & imask_q & wdata_i;
    if (|ev) istat_d[DMA_CAUSE] = 1'b1;
  end

  always_comb begin
    dicr_d = dicr_q;
    if (wr_dicr_i) dicr_d = (wdata_i & ~FLAG_MASK) | (dicr_q & FLAG_MASK & ~wdata_i);
    dicr_d[FLAG_LSB +: NUM_CH] = dicr_d[FLAG_LSB +: NUM_CH] | ev;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      istat_q <= '0;
      imask_q <= '0;
      dpcr_q  <= '0;
      dicr_q  <= '0;
    end else begin
      istat_q <= istat_d;
      dicr_q  <= dicr_d;
      if (wr_imask_i) imask_q <= wdata_i;
      if (wr_dpcr_i)  dpcr_q  <= wdata_i;
    end
  end

  assign istat_o = istat_q;
  assign imask_o = imask_q;
  assign dpcr_o  = dpcr_q;
  assign dicr_o  = dicr_q;
  assign irq_o   = |(istat_q & imask_q);

  // R2
  istat_no_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_istat_i && ev == '0) |=> (istat_q & ~$past(istat_q)) == '0);
  // R7
  dma_cause_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|ev) |=> istat_q[DMA_CAUSE]);
  // R8
  flag_survives_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|ev) |=> (dicr_q[FLAG_LSB +: NUM_CH] & $past(ev)) == $past(ev));
  // R9
  irq_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past((|ev) || wr_imask_i));
endmodule

// File: rtl/dma_irq_regs.sv
module dma_irq_regs
  import dma_irq_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned NUM_CH = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [NUM_CH-1:0] done_i,
  output logic [NUM_CH-1:0] start_o,
  output logic              irq_o
);
  localparam int unsigned WA_W = ADDR_W - 2;

  logic [WA_W-1:0] waddr;
  logic hit_istat, hit_imask, hit_dpcr, hit_dicr;
  logic [DATA_W-1:0] istat, imask, dpcr, dicr;
  logic [DATA_W-1:0] ch_rdata [NUM_CH];
  ch_reg_e ch_reg;

  assign waddr     = addr_i[ADDR_W-1:2];
  assign hit_istat = waddr == WA_W'(OFS_ISTAT >> 2);
  assign hit_imask = waddr == WA_W'(OFS_IMASK >> 2);
  assign hit_dpcr  = waddr == WA_W'(OFS_DPCR >> 2);
  assign hit_dicr  = waddr == WA_W'(OFS_DICR >> 2);
  assign ch_reg    = ch_reg_e'(addr_i[3:2]);

  dma_irq_ctrl #(.DATA_W(DATA_W), .NUM_CH(NUM_CH)) i_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_istat_i (we_i & hit_istat),
    .wr_imask_i (we_i & hit_imask),
    .wr_dpcr_i  (we_i & hit_dpcr),
    .wr_dicr_i  (we_i & hit_dicr),
    .wdata_i    (wdata_i),
    .done_i     (done_i),
    .istat_o    (istat),
    .imask_o    (imask),
    .dpcr_o     (dpcr),
    .dicr_o     (dicr),
    .irq_o      (irq_o)
  );

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    localparam logic [ADDR_W-5:0] CH_BLOCK = (ADDR_W-4)'((OFS_CH_BASE >> 4) + n);
    logic sel;
    assign sel = addr_i[ADDR_W-1:4] == CH_BLOCK;

    dma_chan_regs #(.DATA_W(DATA_W)) i_chan (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .sel_i   (sel),
      .reg_i   (ch_reg),
      .we_i    (we_i),
      .wdata_i (wdata_i),
      .en_i    (dpcr[4*n+3]),
      .done_i  (done_i[n]),
      .rdata_o (ch_rdata[n]),
      .start_o (start_o[n])
    );
  end

  always_comb begin
    rdata_o = '0;
    if (hit_istat) rdata_o = istat;
    if (hit_imask) rdata_o = imask;
    if (hit_dpcr)  rdata_o = dpcr;
    if (hit_dicr)  rdata_o = dicr;
    for (int n = 0; n < NUM_CH; n++) rdata_o = rdata_o | ch_rdata[n];
  end

  // R5
  start_needs_go_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|start_o) |-> $past(we_i));
endmodule

// File: tb/test_dma_irq_regs.sv
module test_dma_irq_regs;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 7;

  logic clk = 0, rst_n = 0;
  logic [11:0] addr = '0;
  logic we = 0;
  logic [31:0] wdata = '0, rdata;
  logic [NCH-1:0] done = '0, start;
  logic irq;

  int n_tests = 0, n_fail = 0;

  logic [31:0] m_istat, m_imask, m_dpcr, m_dicr;
  logic [31:0] m_madr [NCH], m_bcr [NCH], m_chcr [NCH];

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_irq_regs i_dma_irq_regs (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .done_i(done), .start_o(start), .irq_o(irq)
  );

  initial begin
    #(CLK_PERIOD*200000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: run did not finish (actual hung, expected done)");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [NCH-1:0] cond_m();
    logic [NCH-1:0] c;
    for (int n = 0; n < NCH; n++) c[n] = m_chcr[n][24] & m_dpcr[4*n+3];
    return c;
  endfunction

  function automatic logic [31:0] exp_rd(input logic [11:0] a);
    if (a == 12'h070) return m_istat;
    if (a == 12'h074) return m_imask;
    if (a == 12'h0F0) return m_dpcr;
    if (a == 12'h0F4) return m_dicr;
    for (int n = 0; n < NCH; n++) begin
      if (a == 12'h080 + 12'(16*n)) return m_madr[n];
      if (a == 12'h084 + 12'(16*n)) return m_bcr[n];
      if (a == 12'h088 + 12'(16*n)) return m_chcr[n];
    end
    return 32'h0;
  endfunction

  task automatic model_apply(input logic w, input logic [11:0] a, input logic [31:0] d,
                             input logic [NCH-1:0] dn);
    logic [NCH-1:0] ev;
    ev = dn & m_dicr[16 +: NCH];
    if (w) begin
      if (a == 12'h070) m_istat = m_istat & m_imask & d;
      if (a == 12'h074) m_imask = d;
      if (a == 12'h0F0) m_dpcr = d;
      if (a == 12'h0F4) m_dicr = (d & 32'h00FF_FFFF) | (m_dicr & ~d & 32'hFF00_0000);
      for (int n = 0; n < NCH; n++) begin
        if (a == 12'h080 + 12'(16*n)) m_madr[n] = d;
        if (a == 12'h084 + 12'(16*n)) m_bcr[n] = d;
        if (a == 12'h088 + 12'(16*n)) m_chcr[n] = d;
      end
    end
    for (int n = 0; n < NCH; n++) if (dn[n]) m_chcr[n][24] = 1'b0;
    m_dicr[24 +: NCH] = m_dicr[24 +: NCH] | ev;
    if (|ev) m_istat[3] = 1'b1;
  endtask

  task automatic step(input logic w, input logic [11:0] a, input logic [31:0] d,
                      input logic [NCH-1:0] dn);
    logic [NCH-1:0] old_c;
    @(negedge clk);
    we = w; addr = a; wdata = d; done = dn;
    @(posedge clk);
    old_c = cond_m();
    model_apply(w, a, d, dn);
    #1;
    chk("R5 start pulse", 32'(start), 32'(cond_m() & ~old_c));
    chk("R9 irq", 32'(irq), 32'(|(m_istat & m_imask)));
    we = 0; done = '0;
  endtask

  task automatic rd_chk(input string tag, input logic [11:0] a);
    addr = a; #1;
    chk(tag, rdata, exp_rd(a));
  endtask

  task automatic rd_all();
    rd_chk("R2 istat", 12'h070);
    rd_chk("R2 imask", 12'h074);
    rd_chk("R4 dpcr", 12'h0F0);
    rd_chk("R3 dicr", 12'h0F4);
    for (int n = 0; n < NCH; n++) begin
      rd_chk("R4 chan addr", 12'h080 + 12'(16*n));
      rd_chk("R4 chan blk", 12'h084 + 12'(16*n));
      rd_chk("R6 chan ctrl", 12'h088 + 12'(16*n));
    end
  endtask

  function automatic logic [11:0] rand_addr();
    int k;
    k = $urandom_range(0, 24);
    if (k == 0) return 12'h070;
    if (k == 1) return 12'h074;
    if (k == 2 || k == 3) return 12'h0F0;
    if (k == 4) return 12'h0F4;
    k = $urandom_range(0, 3*NCH-1);
    return 12'h080 + 12'(16*(k/3)) + 12'(4*(k%3));
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    m_istat = '0; m_imask = '0; m_dpcr = '0; m_dicr = '0;
    for (int n = 0; n < NCH; n++) begin m_madr[n] = '0; m_bcr[n] = '0; m_chcr[n] = '0; end
    #(CLK_PERIOD*2 + 2);
    // R1 reset state
    chk("R1 start", 32'(start), 32'h0);
    chk("R1 irq", 32'(irq), 32'h0);
    rst_n = 1;
    rd_all();
    // R10 unmapped
    rd_chk("R10 unmapped 000", 12'h000);
    rd_chk("R10 unmapped 07C", 12'h07C);
    rd_chk("R10 unmapped 08C", 12'h08C);
    rd_chk("R10 unmapped 0F8", 12'h0F8);

    // R5 R6 R7 directed on channel 4
    step(1, 12'h074, 32'h0000_FFFF, '0);
    step(1, 12'h0F4, 32'h007F_0000, '0);
    step(1, 12'h0F0, 32'h0008_0000, '0);
    step(1, 12'h0C8, 32'h0100_0000, '0);
    chk("R5 ch4 start", 32'(start), 32'h10);
    step(0, 12'h0C8, 32'h0, 7'h10);
    rd_chk("R6 go cleared", 12'h0C8);
    chk("R6 go bit", rdata[24], 1'b0);
    rd_chk("R7 dicr flag", 12'h0F4);
    chk("R7 flag 28", rdata[28], 1'b1);
    rd_chk("R7 istat cause", 12'h070);
    chk("R9 irq up", 32'(irq), 32'h1);
    // R8 clearing status write loses to a same-cycle event
    step(1, 12'h070, 32'h0, 7'h10);
    rd_chk("R8 istat kept", 12'h070);
    // R3 R8 flag clear vs flag set
    step(1, 12'h0F4, 32'hFF7F_0000, 7'h04);
    rd_chk("R3 R8 dicr", 12'h0F4);
    chk("R8 flag 26", rdata[26], 1'b1);
    // R2 write of ones cannot set
    step(1, 12'h070, 32'hFFFF_FFFF, '0);
    rd_chk("R2 no set", 12'h070);
    // R8 done beats go write
    step(1, 12'h0C8, 32'h0100_0000, 7'h10);
    rd_chk("R8 go killed", 12'h0C8);
    // R7 no enable no flag
    step(1, 12'h0F4, 32'hFF00_0000, '0);
    step(1, 12'h070, 32'h0, '0);
    step(0, 12'h0, 32'h0, 7'h7F);
    rd_chk("R7 no enable dicr", 12'h0F4);
    rd_chk("R7 no enable istat", 12'h070);

    for (int i = 0; i < 3000; i++) begin
      logic [NCH-1:0] dn;
      dn = ($urandom_range(0, 3) == 0) ? NCH'($urandom) : '0;
      step($urandom_range(0, 3) != 0, rand_addr(), $urandom, dn);
      if (i % 50 == 0) rd_all();
    end
    rd_all();

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule